// File: doc/BRIEF.md
# Multilevel Wavelet Decomposition Sequencer

This block runs a multi-level two-dimensional wavelet decomposition of an N x N image through one shared filter datapath. The filter arithmetic sits outside the block and is reached through a plain stream interface. The sequencer sends samples into that datapath and takes its subband results back. It also keeps an on-chip buffer of (N/2)x(N/2) samples that holds the low-low (LL) subband between levels.

In level 1 the datapath input is fed from the external raster pixel stream. Every later level is fed from the LL samples that the previous level stored, read back in the order in which they were produced. Levels run strictly one after another, up to a depth J that is taken from an input port when a new image starts. At each level the three detail subbands (LH, HL, HH) go to the result port with a level tag. The LL subband is written back to the buffer, except at level J, where it goes to the result port. Between levels the block sends a one-cycle clear pulse to the datapath's vertical line delays. It also keeps the datapath informed of the current line length.

Reads and writes of the buffer use separate counters. At any level the write counter trails the read counter, because four inputs yield one LL sample. Each level's LL is packed densely from address 0.

Top module: `wdsSeq`

## Requirements
- R1: After reset, `done`, `dpInValid`, `dpClear` and `resValid` are all 0.
- R2: During level 1 each cycle with `pixValid` high passes `pixIn` to `dpInData` with `dpInValid` one cycle later, in order. `pixValid` has no effect while idle, after `done`, or in any level above 1.
- R3: When level j (j >= 2) begins, the block feeds the datapath exactly (N>>(j-1))^2 samples from the buffer. These are the LL outputs of level j-1, in the order the datapath produced them, at one sample per cycle.
- R4: Band codes on `dpOutBand` and `resBand` are 0=LL, 1=LH, 2=HL, 3=HH. Every LH, HL and HH output appears on the result port one cycle later, in order, with `resLevel` equal to the level that produced it.
- R5: LL outputs of levels below J never reach the result port. LL outputs of level J do reach it.
- R6: A level ends with its (N>>(j-1))^2-th datapath output. After every level except the last, `dpClear` is high for exactly one cycle, so an image yields J-1 pulses.
- R7: While level j is fed, `dpLineLen` equals N>>j.
- R8: `done` rises in the cycle after the final output of level J is accepted. A `start` pulse while an image is in progress is ignored: it does not change J and does not restart the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new image (ignored while busy) |
| levels | input | LW | Decomposition depth J, 1..log2(N)-1, sampled at start |
| pixValid | input | 1 | External pixel strobe |
| pixIn | input | DW | External raster pixel |
| dpInValid | output | 1 | Sample strobe to the datapath |
| dpInData | output | DW | Sample to the datapath |
| dpLineLen | output | log2(N) | Line length for the datapath's vertical delays |
| dpClear | output | 1 | One-cycle clear of the datapath line delays |
| dpOutValid | input | 1 | Datapath result strobe |
| dpOutBand | input | 2 | Datapath result subband code |
| dpOutData | input | DW | Datapath result sample |
| resValid | output | 1 | Result strobe |
| resBand | output | 2 | Result subband code |
| resLevel | output | LW | Level that produced the result |
| resData | output | DW | Result sample |
| done | output | 1 | Final level finished |

## Verification
The bench stands in for the datapath and follows the stream from both sides. A fault in the level counter shows up at once as a wrong `dpLineLen`, a wrong `resLevel` tag, or an LL sample that leaks to or goes missing from the result port within the first level transition. A fault in the read or write counters of the buffer corrupts the first sample fed into level 2, so the expected-input queue reports it at that sample. A fault in the end-of-level count shifts the `dpClear` pulse and the `done` rise. It is caught by the per-image pulse count, and as soon as the next level's inputs start early or late.

// File: rtl/wdsPkg.sv
package wdsPkg;
  typedef enum logic [1:0] {BAND_LL = 2'd0, BAND_LH = 2'd1, BAND_HL = 2'd2, BAND_HH = 2'd3} bandT;

  typedef struct packed {
    logic live;    // an image is in progress
    logic pixEn;   // level 1: accept external pixels
    logic rdEn;    // later levels: read buffer this cycle
    logic holdLL;  // current level is not the last: LL goes to buffer
    logic clear;   // level boundary pulse
    logic newImg;  // first cycle of a new image
  } ctrlT;
endpackage

// File: rtl/wdsCtrl.sv
module wdsCtrl
  import wdsPkg::*;
#(
  parameter int N  = 16,
  parameter int LW = 3,
  parameter int AW = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [LW-1:0]           levels,
  input  logic                    dpOutValid,
  output ctrlT                    ctrl,
  output logic [AW-1:0]           rdAddr,
  output logic [LW-1:0]           level,
  output logic [$clog2(N)-1:0]    lineLen,
  output logic                    done
);
  localparam int LOGN = $clog2(N);
  localparam int CW   = 2 * LOGN + 1;
  localparam logic [CW-1:0] FULL = CW'(N * N);

  logic          busy, feeding, clearQ, newImgQ;
  logic [LW-1:0] jReg;
  logic [CW-1:0] outCnt, rdCnt, lvlTotal;

  // samples in and out of the current level: (N >> (level-1))^2
  assign lvlTotal = FULL >> (2 * (int'(level) - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      feeding <= 1'b0;
      clearQ  <= 1'b0;
      newImgQ <= 1'b0;
      level   <= LW'(1);
      jReg    <= LW'(1);
      outCnt  <= '0;
      rdCnt   <= '0;
    end else begin
      clearQ  <= 1'b0;
      newImgQ <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        level   <= LW'(1);
        jReg    <= levels;
        outCnt  <= '0;
        rdCnt   <= '0;
        feeding <= 1'b0;
        newImgQ <= 1'b1;
      end else begin
        if (feeding) begin
          if (rdCnt == lvlTotal - 1'b1) feeding <= 1'b0;
          else rdCnt <= rdCnt + 1'b1;
        end
        if (busy && dpOutValid) begin
          if (outCnt == lvlTotal - 1'b1) begin
            outCnt <= '0;
            if (level == jReg) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              clearQ  <= 1'b1;
              level   <= level + 1'b1;
              feeding <= 1'b1;
              rdCnt   <= '0;
            end
          end else begin
            outCnt <= outCnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    ctrl        = '0;
    ctrl.live   = busy;
    ctrl.pixEn  = busy && (level == LW'(1));
    ctrl.rdEn   = feeding;
    ctrl.holdLL = (level != jReg);
    ctrl.clear  = clearQ;
    ctrl.newImg = newImgQ;
  end

  assign rdAddr  = rdCnt[AW-1:0];
  assign lineLen = LOGN'(N >> level);

  p_clear_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    clearQ |=> !clearQ);
  p_clear_mid_image_r6: assert property (@(posedge clk) disable iff (!rstN)
    clearQ |-> (busy && level >= LW'(2) && level <= jReg));
  p_feed_later_r3: assert property (@(posedge clk) disable iff (!rstN)
    feeding |-> (busy && level >= LW'(2)));
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !feeding));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(jReg));
endmodule

// File: rtl/wdsPath.sv
module wdsPath
  import wdsPkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 12,
  parameter int LW = 3,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlT          ctrl,
  input  logic [AW-1:0] rdAddr,
  input  logic [LW-1:0] level,
  input  logic          pixValid,
  input  logic [DW-1:0] pixIn,
  output logic          dpInValid,
  output logic [DW-1:0] dpInData,
  input  logic          dpOutValid,
  input  logic [1:0]    dpOutBand,
  input  logic [DW-1:0] dpOutData,
  output logic          resValid,
  output logic [1:0]    resBand,
  output logic [LW-1:0] resLevel,
  output logic [DW-1:0] resData
);
  localparam int DEPTH = (N / 2) * (N / 2);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] bufQ, pixQ;
  logic          bufV, pixV, wrEn;
  logic [AW-1:0] wrAddr;

  assign wrEn = ctrl.live && dpOutValid && (bandT'(dpOutBand) == BAND_LL) && ctrl.holdLL;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= dpOutData;
    if (ctrl.rdEn) bufQ <= mem[rdAddr];
    pixQ <= pixIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufV     <= 1'b0;
      pixV     <= 1'b0;
      wrAddr   <= '0;
      resValid <= 1'b0;
      resBand  <= '0;
      resLevel <= '0;
      resData  <= '0;
    end else begin
      bufV     <= ctrl.rdEn;
      pixV     <= ctrl.pixEn && pixValid;
      resValid <= 1'b0;
      if (ctrl.clear || ctrl.newImg) wrAddr <= '0;
      else if (wrEn) wrAddr <= wrAddr + 1'b1;
      if (ctrl.live && dpOutValid && !wrEn) begin
        resValid <= 1'b1;
        resBand  <= dpOutBand;
        resLevel <= level;
        resData  <= dpOutData;
      end
    end
  end

  // source multiplexer: buffer for later levels, pixels for level 1
  assign dpInValid = bufV || pixV;
  assign dpInData  = bufV ? bufQ : pixQ;

  p_write_behind_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ctrl.rdEn) |-> (wrAddr < rdAddr));
  p_single_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(bufV && pixV));
  p_ll_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && bandT'(resBand) == BAND_LL) |-> $past(!ctrl.holdLL));
endmodule

// File: rtl/wdsSeq.sv
module wdsSeq
  import wdsPkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 12,
  parameter int LW = $clog2($clog2(N)) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [LW-1:0]        levels,
  input  logic                 pixValid,
  input  logic [DW-1:0]        pixIn,
  output logic                 dpInValid,
  output logic [DW-1:0]        dpInData,
  output logic [$clog2(N)-1:0] dpLineLen,
  output logic                 dpClear,
  input  logic                 dpOutValid,
  input  logic [1:0]           dpOutBand,
  input  logic [DW-1:0]        dpOutData,
  output logic                 resValid,
  output logic [1:0]           resBand,
  output logic [LW-1:0]        resLevel,
  output logic [DW-1:0]        resData,
  output logic                 done
);
  localparam int AW = $clog2((N / 2) * (N / 2));

  ctrlT          ctrl;
  logic [AW-1:0] rdAddr;
  logic [LW-1:0] level;

  wdsCtrl #(.N(N), .LW(LW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .levels(levels),
    .dpOutValid(dpOutValid), .ctrl(ctrl), .rdAddr(rdAddr),
    .level(level), .lineLen(dpLineLen), .done(done)
  );

  wdsPath #(.N(N), .DW(DW), .LW(LW), .AW(AW)) u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rdAddr(rdAddr), .level(level),
    .pixValid(pixValid), .pixIn(pixIn),
    .dpInValid(dpInValid), .dpInData(dpInData),
    .dpOutValid(dpOutValid), .dpOutBand(dpOutBand), .dpOutData(dpOutData),
    .resValid(resValid), .resBand(resBand), .resLevel(resLevel), .resData(resData)
  );

  assign dpClear = ctrl.clear;
endmodule

// File: tb/wdsSeq_bench.sv
module wdsSeq_bench;
  localparam int N  = 16;
  localparam int DW = 12;
  localparam int LW = 3;
  localparam int LOGN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LW-1:0] levels = '0;
  logic pixValid = 1'b0;
  logic [DW-1:0] pixIn = '0;
  logic dpInValid, dpClear, resValid, done;
  logic [DW-1:0] dpInData, resData;
  logic [LOGN-1:0] dpLineLen;
  logic [1:0] resBand;
  logic [LW-1:0] resLevel;
  logic dpOutValid = 1'b0;
  logic [1:0] dpOutBand = '0;
  logic [DW-1:0] dpOutData = '0;

  int checks = 0, errors = 0, cyc = 0, clrCount = 0;
  bit finished = 0;
  int expDp[$];     // expected datapath input values
  int expLvl[$];    // level of each expected datapath input
  int expRes[$];    // band<<20 | level<<16 | data
  int grp[$];
  int outQ[$];      // band<<16 | data, driven by datapath stand-in

  always #2.5 clk = ~clk;

  wdsSeq #(.N(N), .DW(DW), .LW(LW)) u_wdsSeq (
    .clk(clk), .rstN(rstN), .start(start), .levels(levels),
    .pixValid(pixValid), .pixIn(pixIn),
    .dpInValid(dpInValid), .dpInData(dpInData), .dpLineLen(dpLineLen), .dpClear(dpClear),
    .dpOutValid(dpOutValid), .dpOutBand(dpOutBand), .dpOutData(dpOutData),
    .resValid(resValid), .resBand(resBand), .resLevel(resLevel), .resData(resData),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Datapath stand-in and input monitor: groups of four inputs a,b,c,d give
  // LL=(a+b+c+d)/4, LH=a, HL=b, HH=d.
  always @(negedge clk) begin
    if (dpInValid) begin
      if (expDp.size() == 0) begin
        check(0, "R2 stray datapath input", dpInData, -1);
      end else begin
        int e, l;
        e = expDp.pop_front();
        l = expLvl.pop_front();
        if (l == 1) check(dpInData == DW'(e), "R2 pixel forward", dpInData, e);
        else check(dpInData == DW'(e), "R3 buffered LL feed", dpInData, e);
        check(dpLineLen == LOGN'(N >> l), "R7 line length", dpLineLen, N >> l);
      end
      grp.push_back(int'(dpInData));
      if (grp.size() == 4) begin
        outQ.push_back((0 << 16) | ((grp[0] + grp[1] + grp[2] + grp[3]) >> 2));
        outQ.push_back((1 << 16) | grp[0]);
        outQ.push_back((2 << 16) | grp[1]);
        outQ.push_back((3 << 16) | grp[3]);
        grp.delete();
      end
    end
    if (outQ.size() > 0) begin
      int o;
      o = outQ.pop_front();
      dpOutValid <= 1'b1;
      dpOutBand  <= 2'(o >> 16);
      dpOutData  <= DW'(o & 16'hffff);
    end else begin
      dpOutValid <= 1'b0;
    end
  end

  // Result scoreboard monitor
  always @(negedge clk) begin
    if (dpClear) clrCount++;
    if (resValid) begin
      int got;
      got = (int'(resBand) << 20) | (int'(resLevel) << 16) | int'(resData);
      if (expRes.size() == 0) begin
        check(0, resBand == 2'd0 ? "R5 unexpected LL" : "R4 unexpected result", got, -1);
      end else begin
        int e;
        e = expRes.pop_front();
        check(got == e, (e >> 20) == 0 ? "R5 final LL result" : "R4 detail result", got, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic runImage(input int jv, input int seed, input int gap);
    int cur[$];
    int nxt[$];
    int img[$];
    expDp.delete(); expLvl.delete(); expRes.delete();
    for (int i = 0; i < N * N; i++) cur.push_back((i * seed + 13 * (i >> 4)) & 12'hfff);
    img = cur;
    for (int l = 1; l <= jv; l++) begin
      nxt.delete();
      for (int g = 0; g < cur.size(); g += 4) begin
        int ll;
        for (int k = 0; k < 4; k++) begin
          expDp.push_back(cur[g + k]);
          expLvl.push_back(l);
        end
        ll = (cur[g] + cur[g + 1] + cur[g + 2] + cur[g + 3]) >> 2;
        if (l == jv) expRes.push_back((0 << 20) | (l << 16) | ll);
        expRes.push_back((1 << 20) | (l << 16) | cur[g]);
        expRes.push_back((2 << 20) | (l << 16) | cur[g + 1]);
        expRes.push_back((3 << 20) | (l << 16) | cur[g + 3]);
        nxt.push_back(ll);
      end
      cur = nxt;
    end
    clrCount = 0;
    @(negedge clk);
    levels = LW'(jv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R8 done cleared at start", done, 0);
    for (int i = 0; i < N * N; i++) begin
      pixIn = DW'(img[i]);
      pixValid = 1'b1;
      @(negedge clk);
      if (gap != 0 && (i % gap) == 0) begin
        pixValid = 1'b0;
        @(negedge clk);
      end
    end
    pixValid = 1'b0;
    if (jv > 1) begin
      for (int t = 0; t < 1000 && clrCount == 0; t++) @(negedge clk);
      // later levels: pixels and a new start must both be ignored
      pixValid = 1'b1;
      pixIn = 12'h5a5;
      levels = LW'(1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 5000 && !done; t++) @(negedge clk);
    pixValid = 1'b0;
    check(done == 1'b1, "R8 done after final level", done, 1);
    @(negedge clk);
    @(negedge clk);
    check(expRes.size() == 0, "R5 all results seen", expRes.size(), 0);
    check(expDp.size() == 0, "R3 all inputs fed", expDp.size(), 0);
    check(clrCount == jv - 1, "R6 clear pulse count", clrCount, jv - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(dpInValid == 1'b0, "R1 dpInValid after reset", dpInValid, 0);
    check(dpClear == 1'b0, "R1 dpClear after reset", dpClear, 0);
    check(resValid == 1'b0, "R1 resValid after reset", resValid, 0);
    // R2: pixels while idle are ignored
    pixValid = 1'b1;
    pixIn = 12'h123;
    repeat (5) @(negedge clk);
    pixValid = 1'b0;
    @(negedge clk);
    check(dpInValid == 1'b0, "R2 idle pixels ignored", dpInValid, 0);
    runImage(3, 37, 0);
    runImage(1, 11, 5);
    runImage(2, 101, 3);
    // R2: pixels after done are ignored
    pixValid = 1'b1;
    repeat (4) @(negedge clk);
    pixValid = 1'b0;
    @(negedge clk);
    check(dpInValid == 1'b0, "R2 pixels after done ignored", dpInValid, 0);
    check(done == 1'b1, "R8 done holds", done, 1);
    summary();
  end
endmodule